// File: doc/BRIEF.md
# Banked Register Transfer Controller

This block sequences register traffic inside a reconfigurable compute cluster whose register file is split into equal banks (four banks of eight 32-bit registers by default). A small microprogram, loaded through a write port, steps one microinstruction per cycle. Each microinstruction either copies a register from one bank to another, sends a register's value out on the network, does nothing, or halts. Every microinstruction also picks the next address, with an optional branch on an external condition flag.

Register values come from, and go to, the banks over per-bank ports. Each bank has one read port and one write port, and the register values are visible on the read side without delay. Data from the network can arrive in any cycle and must be written into its bank at once. When that data and a scheduled bank-to-bank copy target the same bank's write port in the same cycle, the network write wins. The controller raises a cluster-wide stall for that cycle and holds its sequencer, and the copy is tried again on the next cycle. Writes that target different banks go ahead together.

Top module: `brt_xfer_ctrl`

## Requirements
- R1: A 5-bit register number selects the bank with its upper 2 bits and the entry within the bank with its lower 3 bits. This holds for both the network receive index and the send destination index.
- R2: In any cycle, at most one bank read port is enabled, and each bank write port carries at most one write.
- R3: A copy microinstruction (type 1) drives the source register's value onto the destination bank's write port, at the destination index, in the same cycle.
- R4: A send microinstruction (type 2) raises tx_valid with the source register's value and the destination register number. The sequencer holds until tx_ready is high.
- R5: A network arrival (rx_valid) writes rx_data into the register named by rx_reg in the same cycle, whether or not the sequencer is running.
- R6: When an arrival and a copy target the same bank, cluster_stall is high for that cycle. The arrival is written, the copy is suppressed, and the sequencer holds. The copy is retried on each following cycle until it completes.
- R7: When an arrival and a copy target different banks, both writes happen in the same cycle and cluster_stall stays low.
- R8: After an instruction completes, the sequencer moves to the branch target when the branch-enable bit and cond_flag are both set, and to the next field otherwise. A halt instruction (type 3) holds. While seq_run is low, the sequencer holds and issues no transfers.
- R9: ucode_we writes ucode_wdata into entry ucode_addr. The word layout, from MSB to LSB, is: type[20:19], src bank[18:17], src index[16:14], dst bank[13:12], dst index[11:9], branch enable[8], branch target[7:4], next[3:0]. Type 0 is no-op.
- R10: Reset sets the sequencer address to 0. With seq_run low after reset, no write, send or stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ucode_we | input | 1 | Microprogram write strobe |
| ucode_addr | input | 4 | Microprogram write address |
| ucode_wdata | input | 21 | Microprogram word |
| seq_run | input | 1 | Sequencer enable |
| cond_flag | input | 1 | Branch condition |
| bank_rd_en | output | 4 | Per-bank read enable |
| bank_rd_idx | output | 12 | Per-bank read index, 3 bits per bank |
| bank_rd_data | input | 128 | Per-bank read data, 32 bits per bank |
| bank_wr_en | output | 4 | Per-bank write enable |
| bank_wr_idx | output | 12 | Per-bank write index |
| bank_wr_data | output | 128 | Per-bank write data |
| rx_valid | input | 1 | Network arrival strobe |
| rx_reg | input | 5 | Arrival register number |
| rx_data | input | 32 | Arrival data |
| tx_valid | output | 1 | Send request |
| tx_ready | input | 1 | Send port ready |
| tx_reg | output | 5 | Send destination register number |
| tx_data | output | 32 | Send data |
| cluster_stall | output | 1 | Cluster-wide stall on write-port collision |

## Verification
Copies run alone, alongside an arrival on another bank, and against arrivals on the same bank in two back-to-back cycles. This separates the parallel case from a single stall and from a repeated retry. Sends are held against a not-ready port for several cycles, which shows that the sequencer holds rather than dropping or repeating the send. The same branch instruction is run with the flag high and then low, and the two paths use distinct destination numbers so the address taken is visible at the send port. A reload of entry 0 shows that the microprogram write port takes effect.

// File: rtl/brt_pkg.sv
package brt_pkg;
   typedef enum logic [1:0] {
      OP_NOP  = 2'd0,
      OP_MOVE = 2'd1,
      OP_SEND = 2'd2,
      OP_HALT = 2'd3
   } brt_op_e;
endpackage

// File: rtl/brt_ustore.sv
module brt_ustore #(
   parameter int WORD_W = 21,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/brt_seq.sv
module brt_seq
   import brt_pkg::*;
#(
   parameter int PC_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  brt_op_e         op,
   input  logic            stall,
   input  logic            tx_ready,
   input  logic            br_en,
   input  logic            cond,
   input  logic [PC_W-1:0] br_tgt,
   input  logic [PC_W-1:0] nxt,
   output logic [PC_W-1:0] pc
);
   logic hold;
   logic [PC_W-1:0] pc_next;

   always_comb begin
      hold    = (op == OP_HALT) || stall || ((op == OP_SEND) && !tx_ready);
      pc_next = (br_en && cond) ? br_tgt : nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             pc <= '0;
      else if (run && !hold)  pc <= pc_next;
   end

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && stall) |=> (pc == $past(pc)));                          // R6
   AST_SEND_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_SEND && !tx_ready) |=> (pc == $past(pc)));     // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pc));                                          // R8
endmodule

// File: rtl/brt_wport.sv
module brt_wport #(
   parameter int NUM_BANKS = 4,
   parameter int IDX_W     = 3,
   parameter int DATA_W    = 32,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_valid,
   input  logic [BANK_W-1:0]           rx_bank,
   input  logic [IDX_W-1:0]            rx_idx,
   input  logic [DATA_W-1:0]           rx_data,
   input  logic                        mv_valid,
   input  logic [BANK_W-1:0]           mv_bank,
   input  logic [IDX_W-1:0]            mv_idx,
   input  logic [DATA_W-1:0]           mv_data,
   output logic [NUM_BANKS-1:0]        wr_en,
   output logic [NUM_BANKS*IDX_W-1:0]  wr_idx,
   output logic [NUM_BANKS*DATA_W-1:0] wr_data,
   output logic                        stall
);
   logic [NUM_BANKS-1:0] clash;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic rx_hit, mv_hit;
      assign rx_hit = rx_valid && (rx_bank == BANK_W'(b));
      assign mv_hit = mv_valid && (mv_bank == BANK_W'(b));
      assign clash[b] = rx_hit && mv_hit;
      assign wr_en[b] = rx_hit || mv_hit;
      assign wr_idx[b*IDX_W +: IDX_W]    = rx_hit ? rx_idx  : mv_idx;
      assign wr_data[b*DATA_W +: DATA_W] = rx_hit ? rx_data : mv_data;
   end

   assign stall = |clash;

   AST_RX_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> wr_en[rx_bank]);                                   // R5
   AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (rx_valid && mv_valid && rx_bank == mv_bank));        // R6
   AST_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mv_valid && rx_bank != mv_bank)
         |-> (!stall && $countones(wr_en) == 2));                     // R7
endmodule

// File: rtl/brt_xfer_ctrl.sv
module brt_xfer_ctrl
   import brt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_BANKS   = 4,
   parameter int BANK_DEPTH  = 8,
   parameter int UCODE_DEPTH = 16,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int IDX_W  = $clog2(BANK_DEPTH),
   localparam int REG_W  = BANK_W + IDX_W,
   localparam int PC_W   = $clog2(UCODE_DEPTH),
   localparam int UW     = 2 + 2*REG_W + 1 + 2*PC_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ucode_we,
   input  logic [PC_W-1:0]             ucode_addr,
   input  logic [UW-1:0]               ucode_wdata,
   input  logic                        seq_run,
   input  logic                        cond_flag,
   output logic [NUM_BANKS-1:0]        bank_rd_en,
   output logic [NUM_BANKS*IDX_W-1:0]  bank_rd_idx,
   input  logic [NUM_BANKS*DATA_W-1:0] bank_rd_data,
   output logic [NUM_BANKS-1:0]        bank_wr_en,
   output logic [NUM_BANKS*IDX_W-1:0]  bank_wr_idx,
   output logic [NUM_BANKS*DATA_W-1:0] bank_wr_data,
   input  logic                        rx_valid,
   input  logic [REG_W-1:0]            rx_reg,
   input  logic [DATA_W-1:0]           rx_data,
   output logic                        tx_valid,
   input  logic                        tx_ready,
   output logic [REG_W-1:0]            tx_reg,
   output logic [DATA_W-1:0]           tx_data,
   output logic                        cluster_stall
);
   // field offsets, LSB upward
   localparam int F_NXT  = 0;
   localparam int F_BRT  = F_NXT + PC_W;
   localparam int F_BRE  = F_BRT + PC_W;
   localparam int F_DIDX = F_BRE + 1;
   localparam int F_DBNK = F_DIDX + IDX_W;
   localparam int F_SIDX = F_DBNK + BANK_W;
   localparam int F_SBNK = F_SIDX + IDX_W;
   localparam int F_OP   = F_SBNK + BANK_W;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (BANK_DEPTH < 2 || (BANK_DEPTH & (BANK_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("BANK_DEPTH must be a power of two, at least 2");
   end
   if (UCODE_DEPTH < 2 || (UCODE_DEPTH & (UCODE_DEPTH - 1)) != 0) begin : g_bad_ucode
      $error("UCODE_DEPTH must be a power of two, at least 2");
   end

   logic [PC_W-1:0]   pc;
   logic [UW-1:0]     uword;
   brt_op_e           op;
   logic [BANK_W-1:0] src_bank, dst_bank;
   logic [IDX_W-1:0]  src_idx, dst_idx;
   logic              br_en;
   logic [PC_W-1:0]   br_tgt, nxt;
   logic [DATA_W-1:0] src_data;
   logic              mv_valid;

   brt_ustore #(.WORD_W(UW), .DEPTH(UCODE_DEPTH)) u_store (
      .clk(clk), .we(ucode_we), .waddr(ucode_addr), .wdata(ucode_wdata),
      .raddr(pc), .rdata(uword)
   );

   assign op       = brt_op_e'(uword[F_OP +: 2]);
   assign src_bank = uword[F_SBNK +: BANK_W];
   assign src_idx  = uword[F_SIDX +: IDX_W];
   assign dst_bank = uword[F_DBNK +: BANK_W];
   assign dst_idx  = uword[F_DIDX +: IDX_W];
   assign br_en    = uword[F_BRE];
   assign br_tgt   = uword[F_BRT +: PC_W];
   assign nxt      = uword[F_NXT +: PC_W];

   assign src_data = bank_rd_data[src_bank*DATA_W +: DATA_W];
   assign mv_valid = seq_run && (op == OP_MOVE);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rd
      assign bank_rd_en[b] = seq_run && (op == OP_MOVE || op == OP_SEND)
                             && (src_bank == BANK_W'(b));
      assign bank_rd_idx[b*IDX_W +: IDX_W] = src_idx;
   end

   assign tx_valid = seq_run && (op == OP_SEND);
   assign tx_reg   = {dst_bank, dst_idx};
   assign tx_data  = src_data;

   brt_wport #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_wport (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_bank(rx_reg[REG_W-1 -: BANK_W]),
      .rx_idx(rx_reg[IDX_W-1:0]), .rx_data(rx_data),
      .mv_valid(mv_valid), .mv_bank(dst_bank), .mv_idx(dst_idx), .mv_data(src_data),
      .wr_en(bank_wr_en), .wr_idx(bank_wr_idx), .wr_data(bank_wr_data),
      .stall(cluster_stall)
   );

   brt_seq #(.PC_W(PC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(seq_run), .op(op), .stall(cluster_stall),
      .tx_ready(tx_ready), .br_en(br_en), .cond(cond_flag),
      .br_tgt(br_tgt), .nxt(nxt), .pc(pc)
   );

   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_rd_en));                                          // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_run |-> (!tx_valid && bank_rd_en == '0));                  // R8
endmodule

// File: tb/brt_xfer_ctrl_bench.sv
module brt_xfer_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          ucode_we = 0;
   logic [3:0]    ucode_addr = 0;
   logic [20:0]   ucode_wdata = 0;
   logic          seq_run = 0, cond_flag = 0;
   logic [3:0]    bank_rd_en;
   logic [11:0]   bank_rd_idx;
   logic [127:0]  bank_rd_data;
   logic [3:0]    bank_wr_en;
   logic [11:0]   bank_wr_idx;
   logic [127:0]  bank_wr_data;
   logic          rx_valid = 0;
   logic [4:0]    rx_reg = 0;
   logic [31:0]   rx_data = 0;
   logic          tx_valid, tx_ready = 0;
   logic [4:0]    tx_reg;
   logic [31:0]   tx_data;
   logic          cluster_stall;

   int nchk = 0, nerr = 0;
   bit done = 0;
   logic [31:0] mregs [4][8];

   always #(CLK_PERIOD/2) clk = ~clk;

   brt_xfer_ctrl u_brt_xfer_ctrl (.*);

   always_comb begin
      for (int b = 0; b < 4; b++)
         bank_rd_data[b*32 +: 32] = mregs[b][bank_rd_idx[b*3 +: 3]];
   end

   function automatic logic [31:0] val(int b, int i);
      return 32'hA500_0000 + 32'(b*16 + i);
   endfunction

   function automatic logic [20:0] mk(logic [1:0] op, logic [1:0] sb, logic [2:0] si,
         logic [1:0] db, logic [2:0] di, logic be, logic [3:0] bt, logic [3:0] nx);
      return {op, sb, si, db, di, be, bt, nx};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // capture DUT writes, commit them at the edge, return at the next negedge
   task automatic tick();
      logic [3:0] en = bank_wr_en;
      logic [11:0] ix = bank_wr_idx;
      logic [127:0] dt = bank_wr_data;
      @(posedge clk);
      for (int b = 0; b < 4; b++)
         if (en[b]) mregs[b][ix[b*3 +: 3]] = dt[b*32 +: 32];
      @(negedge clk);
   endtask

   task automatic settle(); #1; endtask

   task automatic load(logic [3:0] a, logic [20:0] w);
      ucode_we = 1; ucode_addr = a; ucode_wdata = w;
      tick();
      ucode_we = 0;
   endtask

   task automatic do_reset();
      seq_run = 0; rst_n = 0;
      tick(); tick();
      rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      settle();
      chk("R10", "stall", 32'(cluster_stall), 0);
      chk("R10", "wr_en", 32'(bank_wr_en), 0);
      chk("R10", "tx_valid", 32'(tx_valid), 0);
      tick();
   endtask

   task automatic t_fill();
      seq_run = 0;
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 8; i++) begin
            rx_valid = 1; rx_reg = 5'(b*8 + i); rx_data = val(b, i);
            settle();
            chk("R5", "rx wr_en", 32'(bank_wr_en), 32'(1 << b));
            chk("R1", "rx wr_idx", 32'(bank_wr_idx[b*3 +: 3]), 32'(i));
            chk("R5", "rx wr_data", bank_wr_data[b*32 +: 32], val(b, i));
            tick();
         end
      rx_valid = 0;
   endtask

   task automatic t_move_send();
      load(0, mk(2'd1, 2'd0, 3'd1, 2'd2, 3'd5, 0, 0, 4'd1));
      load(1, mk(2'd2, 2'd2, 3'd5, 2'd3, 3'd7, 0, 0, 4'd2));
      load(2, mk(2'd3, 0, 0, 0, 0, 0, 0, 4'd2));
      do_reset();
      seq_run = 1; tx_ready = 0;
      settle();
      chk("R3", "move wr_en", 32'(bank_wr_en), 32'b0100);
      chk("R3", "move idx", 32'(bank_wr_idx[6 +: 3]), 5);
      chk("R3", "move data", bank_wr_data[64 +: 32], val(0, 1));
      chk("R2", "rd_en", 32'(bank_rd_en), 32'b0001);
      chk("R3", "no stall", 32'(cluster_stall), 0);
      tick();
      for (int k = 0; k < 3; k++) begin
         settle();
         chk("R4", "tx_valid wait", 32'(tx_valid), 1);
         chk("R4", "tx_data", tx_data, val(0, 1));
         chk("R1", "tx_reg", 32'(tx_reg), 32'd31);
         chk("R4", "no write", 32'(bank_wr_en), 0);
         tick();
      end
      tx_ready = 1;
      settle();
      chk("R4", "tx_valid ready", 32'(tx_valid), 1);
      tick();
      for (int k = 0; k < 2; k++) begin
         settle();
         chk("R8", "halt tx", 32'(tx_valid), 0);
         chk("R8", "halt wr", 32'(bank_wr_en), 0);
         tick();
      end
      seq_run = 0;
   endtask

   task automatic t_collide();
      load(0, mk(2'd1, 2'd0, 3'd2, 2'd1, 3'd3, 0, 0, 4'd1));
      load(1, mk(2'd3, 0, 0, 0, 0, 0, 0, 4'd1));
      do_reset();
      seq_run = 1;
      rx_valid = 1; rx_reg = {2'd1, 3'd6}; rx_data = 32'hDEADBEEF;
      settle();
      chk("R6", "stall 1st", 32'(cluster_stall), 1);
      chk("R6", "wr_en 1st", 32'(bank_wr_en), 32'b0010);
      chk("R6", "rx idx wins", 32'(bank_wr_idx[3 +: 3]), 6);
      chk("R6", "rx data wins", bank_wr_data[32 +: 32], 32'hDEADBEEF);
      tick();
      rx_reg = {2'd1, 3'd0}; rx_data = 32'h0000_1234;
      settle();
      chk("R6", "stall 2nd", 32'(cluster_stall), 1);
      chk("R6", "rx data 2nd", bank_wr_data[32 +: 32], 32'h0000_1234);
      tick();
      rx_valid = 0;
      settle();
      chk("R6", "retry stall", 32'(cluster_stall), 0);
      chk("R6", "retry wr_en", 32'(bank_wr_en), 32'b0010);
      chk("R6", "retry idx", 32'(bank_wr_idx[3 +: 3]), 3);
      chk("R6", "retry data", bank_wr_data[32 +: 32], val(0, 2));
      tick();
      settle();
      chk("R6", "after retry", 32'(bank_wr_en), 0);
      seq_run = 0;
      tick();
   endtask

   task automatic t_parallel();
      load(0, mk(2'd1, 2'd3, 3'd0, 2'd2, 3'd1, 0, 0, 4'd1));
      load(1, mk(2'd3, 0, 0, 0, 0, 0, 0, 4'd1));
      do_reset();
      seq_run = 1;
      rx_valid = 1; rx_reg = {2'd3, 3'd4}; rx_data = 32'h5555_AAAA;
      settle();
      chk("R7", "stall", 32'(cluster_stall), 0);
      chk("R7", "wr_en", 32'(bank_wr_en), 32'b1100);
      chk("R7", "move data", bank_wr_data[64 +: 32], val(3, 0));
      chk("R7", "rx idx", 32'(bank_wr_idx[9 +: 3]), 4);
      chk("R7", "rx data", bank_wr_data[96 +: 32], 32'h5555_AAAA);
      tick();
      rx_valid = 0;
      settle();
      chk("R7", "move done once", 32'(bank_wr_en), 0);
      seq_run = 0;
      tick();
   endtask

   task automatic t_branch();
      load(0, mk(2'd0, 0, 0, 0, 0, 1, 4'd5, 4'd1));
      load(1, mk(2'd2, 2'd0, 3'd0, 2'd1, 3'd1, 0, 0, 4'd2));
      load(2, mk(2'd3, 0, 0, 0, 0, 0, 0, 4'd2));
      load(5, mk(2'd2, 2'd0, 3'd3, 2'd2, 3'd2, 0, 0, 4'd2));
      tx_ready = 1;
      for (int c = 1; c >= 0; c--) begin
         do_reset();
         cond_flag = c[0]; seq_run = 1;
         settle();
         chk("R8", "nop no tx", 32'(tx_valid), 0);
         tick();
         settle();
         chk("R8", "branch tx", 32'(tx_valid), 1);
         chk("R8", "branch tx_reg", 32'(tx_reg), c ? 32'b10010 : 32'b01001);
         chk("R8", "branch data", tx_data, c ? val(0, 3) : val(0, 0));
         tick();
         settle();
         chk("R8", "halt after", 32'(tx_valid), 0);
         seq_run = 0;
         tick();
      end
      cond_flag = 0;
   endtask

   task automatic t_idle_reload();
      load(0, mk(2'd1, 2'd0, 3'd0, 2'd2, 3'd0, 0, 0, 4'd1));
      do_reset();
      for (int k = 0; k < 3; k++) begin
         settle();
         chk("R8", "idle wr", 32'(bank_wr_en), 0);
         chk("R8", "idle rd", 32'(bank_rd_en), 0);
         tick();
      end
      load(0, mk(2'd2, 2'd1, 3'd6, 2'd0, 3'd0, 0, 0, 4'd2));
      seq_run = 1; tx_ready = 1;
      settle();
      chk("R9", "reloaded tx", 32'(tx_valid), 1);
      chk("R9", "reloaded data", tx_data, 32'hDEADBEEF);
      chk("R9", "reloaded reg", 32'(tx_reg), 0);
      chk("R9", "no move", 32'(bank_wr_en), 0);
      seq_run = 0;
      tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 8; i++) mregs[b][i] = '0;
      @(negedge clk);
      t_reset();
      t_fill();
      t_move_send();
      t_collide();
      t_parallel();
      t_branch();
      t_idle_reload();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule